// File: doc/BRIEF.md
# DMA External Request Front End

This block sits in front of one DMA channel and turns an active-low external request pin into single-cycle start pulses for the channel engine. The pin goes through a synchronizer and only its falling edge counts. Each accepted edge sets a pending flag. The pending flag launches a transfer once the channel may run. Some conditions make the block drop the edge entirely. Other conditions clear a request that is already pending.

A channel may run only when five inputs agree: the global enable and the channel enable are 1, and the NMI, address-error and transfer-end flags are all 0. A request that arrives while an enable is off is kept and fires later. Software can withdraw a kept request with a fixed sequence: release the pin, then drop the detect-select input.

The block also decodes the 4-bit request-source field into an address mode and a transfer direction. An unsupported code is flagged as invalid and never produces a start pulse.

Top module: `dma_xreq_front`

## Requirements
- R1: A falling edge on `req_ni` passes a 2-flop synchronizer. With all run conditions met, `start_o` is high for exactly one cycle, in the third cycle after the pin is first sampled low. A pin held low does not retrigger.
- R2: An edge accepted while `glb_en_i` or `ch_en_i` is 0 sets `pending_o` and gives no start pulse.
- R3: A pending request produces one `start_o` pulse on the first clock where `glb_en_i`=1, `ch_en_i`=1, and `nmi_flag_i`, `addr_err_i`, `xfer_end_i` are all 0. `pending_o` falls in the same cycle that `start_o` rises.
- R4: An edge is discarded, with `pending_o` staying 0, while any of `xfer_end_i`, `nmi_flag_i`, `addr_err_i` or `standby_i` is 1.
- R5: `nmi_flag_i`=1 or `addr_err_i`=1 clears `pending_o` on the next clock.
- R6: Edges are accepted only while `det_sel_i`=1. With the synchronized pin high, taking `det_sel_i` from 1 to 0 clears `pending_o`. Setting `det_sel_i` back to 1 and asserting the pin again latches a new request.
- R7: `req_src_i`=4'b0000 gives dual-address mode: `single_addr_o`=0, `dev_to_mem_o`=0, `invalid_mode_o`=0.
- R8: `req_src_i`=4'b0010 gives `single_addr_o`=1 and `dev_to_mem_o`=0 (memory to device). `req_src_i`=4'b0011 gives `single_addr_o`=1 and `dev_to_mem_o`=1 (device to memory).
- R9: Any other `req_src_i` value gives `invalid_mode_o`=1, `single_addr_o`=0 and `dev_to_mem_o`=0, and no start pulse is issued. A pending request is still held.
- R10: While `rst_ni`=0, `start_o` and `pending_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | External request pin, active low |
| glb_en_i | input | 1 | Global DMA enable |
| ch_en_i | input | 1 | Channel enable |
| nmi_flag_i | input | 1 | NMI flag |
| addr_err_i | input | 1 | Address-error flag |
| xfer_end_i | input | 1 | Transfer-end flag |
| standby_i | input | 1 | Low-power or standby state |
| det_sel_i | input | 1 | Detect-select; 1 arms edge detection |
| req_src_i | input | 4 | Request-source code |
| start_o | output | 1 | One-cycle transfer start pulse |
| pending_o | output | 1 | Request held pending |
| single_addr_o | output | 1 | 1 = single-address mode |
| dev_to_mem_o | output | 1 | 1 = device to memory direction |
| invalid_mode_o | output | 1 | Unsupported request-source code |

## Verification
A wrong pending flag shows up at the ports within one clock: `pending_o` is that flag. It also shows up later as a missing or extra `start_o` pulse once the run conditions are met. A wrong synchronizer depth or edge detector moves the start pulse away from its fixed three-cycle latency, or turns a held-low pin into repeated pulses. A behavioural model in the bench tracks the pin history and the pending state, and flags any such drift on the first clock where it occurs.

// File: rtl/dma_xreq_pkg.sv
package dma_xreq_pkg;
  localparam int unsigned SRC_W = 4;

  typedef enum logic [1:0] {
    MODE_DUAL = 2'd0,
    MODE_M2D  = 2'd1,
    MODE_D2M  = 2'd2,
    MODE_BAD  = 2'd3
  } xfer_mode_e;

  localparam logic [SRC_W-1:0] SRC_DUAL = 4'b0000;
  localparam logic [SRC_W-1:0] SRC_M2D  = 4'b0010;
  localparam logic [SRC_W-1:0] SRC_D2M  = 4'b0011;
endpackage

// File: rtl/dma_xreq_sync.sv
module dma_xreq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic lvl_o,   // synchronized pin, 1 = negated
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < LEN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= req_ni;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/dma_xreq_dec.sv
module dma_xreq_dec
  import dma_xreq_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  output logic             single_o,
  output logic             d2m_o,
  output logic             bad_o
);
  xfer_mode_e mode;

  always_comb begin
    unique case (src_i)
      SRC_DUAL: mode = MODE_DUAL;
      SRC_M2D:  mode = MODE_M2D;
      SRC_D2M:  mode = MODE_D2M;
      default:  mode = MODE_BAD;
    endcase
  end

  assign single_o = (mode == MODE_M2D) || (mode == MODE_D2M);
  assign d2m_o    = (mode == MODE_D2M);
  assign bad_o    = (mode == MODE_BAD);
endmodule

// File: rtl/dma_xreq_front.sv
module dma_xreq_front
  import dma_xreq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_ni,
  input  logic             glb_en_i,
  input  logic             ch_en_i,
  input  logic             nmi_flag_i,
  input  logic             addr_err_i,
  input  logic             xfer_end_i,
  input  logic             standby_i,
  input  logic             det_sel_i,
  input  logic [SRC_W-1:0] req_src_i,
  output logic             start_o,
  output logic             pending_o,
  output logic             single_addr_o,
  output logic             dev_to_mem_o,
  output logic             invalid_mode_o
);
  logic pin_lvl, pin_fall;
  logic det_sel_q, pend_q, start_q;
  logic run_ok, blocked, accept, cancel, fire;

  dma_xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .lvl_o  (pin_lvl),
    .fall_o (pin_fall)
  );

  dma_xreq_dec u_dec (
    .src_i    (req_src_i),
    .single_o (single_addr_o),
    .d2m_o    (dev_to_mem_o),
    .bad_o    (invalid_mode_o)
  );

  assign run_ok  = glb_en_i & ch_en_i & ~nmi_flag_i & ~addr_err_i & ~xfer_end_i;
  assign blocked = xfer_end_i | nmi_flag_i | addr_err_i | standby_i;
  assign accept  = pin_fall & det_sel_i & ~blocked;
  // withdrawal: pin already released, then detect-select drops
  assign cancel  = det_sel_q & ~det_sel_i & pin_lvl;
  assign fire    = run_ok & ~invalid_mode_o & ~cancel & (pend_q | accept);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_sel_q <= 1'b0;
      pend_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      det_sel_q <= det_sel_i;
      start_q   <= fire;
      if (nmi_flag_i | addr_err_i | cancel | fire) pend_q <= 1'b0;
      else if (accept)                             pend_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign pending_o = pend_q;

  // R3
  start_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  start_drops_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !pending_o);
  // R9
  no_start_on_bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(!invalid_mode_o));
  // R5
  flag_clears_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_flag_i || addr_err_i) |=> !pending_o);
  // R4
  blocked_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pending_o && (xfer_end_i || standby_i || nmi_flag_i || addr_err_i)) |=> !pending_o);
  // R9
  bad_mode_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({invalid_mode_o, single_addr_o}) <= 1);
endmodule

// File: tb/dma_xreq_front_tb.sv
module dma_xreq_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_n = 1'b1, glb_en = 1'b0, ch_en = 1'b0, nmi = 1'b0, ae = 1'b0, te = 1'b0;
  logic stby = 1'b0, det_sel = 1'b0;
  logic [3:0] src = 4'b0000;
  logic start, pend, single, d2m, bad;

  int total = 0, fails = 0, starts = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xreq_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .glb_en_i(glb_en), .ch_en_i(ch_en),
    .nmi_flag_i(nmi), .addr_err_i(ae), .xfer_end_i(te), .standby_i(stby),
    .det_sel_i(det_sel), .req_src_i(src), .start_o(start), .pending_o(pend),
    .single_addr_o(single), .dev_to_mem_o(d2m), .invalid_mode_o(bad)
  );

  // behavioural reference
  bit pin_hist[$];
  bit m_pend, m_start, m_ds_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hist = '{1'b1, 1'b1, 1'b1};
      m_pend = 0; m_start = 0; m_ds_prev = 0;
    end else begin
      bit edge_seen, ok, take, drop, go, src_ok;
      edge_seen = pin_hist[2] && !pin_hist[1];
      src_ok = (src == 4'd0) || (src == 4'd2) || (src == 4'd3);
      ok = glb_en && ch_en && !nmi && !ae && !te;
      take = edge_seen && det_sel && !(te || nmi || ae || stby);
      drop = m_ds_prev && !det_sel && pin_hist[1];
      go = ok && src_ok && !drop && (m_pend || take);
      m_start = go;
      if (nmi || ae || drop || go) m_pend = 0;
      else if (take) m_pend = 1;
      m_ds_prev = det_sel;
      pin_hist.push_front(req_n);
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 start vs model", start, m_start);
      chk("R3 pending vs model", pend, m_pend);
      if (start) starts++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req();
    req_n = 1'b0; cyc(2); req_n = 1'b1; cyc(5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    cyc(2);
    chk("R10 start in reset", start, 0);
    chk("R10 pending in reset", pend, 0);
    rst_n = 1'b1;
    cyc(1);

    for (int c = 0; c < 16; c++) begin
      src = c[3:0]; #1;
      if (c == 0) begin
        chk("R7 single", single, 0); chk("R7 dir", d2m, 0); chk("R7 bad", bad, 0);
      end else if (c == 2) begin
        chk("R8 single m2d", single, 1); chk("R8 dir m2d", d2m, 0); chk("R8 bad", bad, 0);
      end else if (c == 3) begin
        chk("R8 single d2m", single, 1); chk("R8 dir d2m", d2m, 1); chk("R8 bad", bad, 0);
      end else begin
        chk("R9 bad code", bad, 1); chk("R9 single", single, 0); chk("R9 dir", d2m, 0);
      end
    end
    src = 4'b0000;
    cyc(1);

    // R1 latency and no retrigger
    glb_en = 1; ch_en = 1; det_sel = 1; cyc(2);
    s0 = starts;
    req_n = 1'b0;
    cyc(2); chk("R1 no early start", start, 0);
    cyc(1); chk("R1 start at third cycle", start, 1);
    cyc(1); chk("R1 pulse one cycle", start, 0);
    cyc(10); chk("R1 held low one start", starts - s0, 1);
    req_n = 1'b1; cyc(4);

    // R2 held while disabled, R3 launch on enable
    ch_en = 0; s0 = starts;
    pulse_req();
    chk("R2 pending while disabled", pend, 1);
    chk("R2 no start while disabled", starts - s0, 0);
    glb_en = 0; ch_en = 1; cyc(3);
    chk("R2 still held glb off", pend, 1);
    glb_en = 1; cyc(1);
    chk("R3 start on enable", start, 1);
    chk("R3 pending cleared with start", pend, 0);
    cyc(3); chk("R3 single start", starts - s0, 1);

    // R4 discard
    ch_en = 0; te = 1; pulse_req(); chk("R4 xfer_end discards", pend, 0);
    te = 0; stby = 1; pulse_req(); chk("R4 standby discards", pend, 0);
    stby = 0; nmi = 1; pulse_req(); chk("R4 nmi discards", pend, 0);
    nmi = 0; ae = 1; pulse_req(); chk("R4 addr_err discards", pend, 0);
    ae = 0;

    // R5 clear by flags
    pulse_req(); chk("R5 latched", pend, 1);
    nmi = 1; cyc(1); nmi = 0; chk("R5 nmi clears", pend, 0);
    pulse_req(); chk("R5 latched again", pend, 1);
    ae = 1; cyc(1); ae = 0; chk("R5 addr_err clears", pend, 0);

    // R6 cancel and re-arm
    pulse_req(); chk("R6 latched", pend, 1);
    det_sel = 0; cyc(2); chk("R6 cancel clears", pend, 0);
    pulse_req(); chk("R6 ignored while det_sel=0", pend, 0);
    det_sel = 1; cyc(2);
    pulse_req(); chk("R6 rearmed", pend, 1);
    s0 = starts; ch_en = 1; cyc(3); chk("R6 rearmed launches", starts - s0, 1);

    // R9 invalid code never starts
    src = 4'b0101; s0 = starts;
    pulse_req(); cyc(3);
    chk("R9 no start on invalid", starts - s0, 0);
    chk("R9 request kept", pend, 1);
    src = 4'b0010; cyc(3);
    chk("R9 starts after valid code", starts - s0, 1);

    cyc(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, fails);
    $finish;
  end
endmodule